// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache with Access Permissions

This block is a small translation cache that sits beside a processor's load, store and fetch path. Each cycle it can take a 32-bit virtual address, the kind of access and the identifier of the running process. In that same cycle it returns a 28-bit physical address, together with an indication of whether the translation was found and whether the access breaks the page's permissions. Pages are 64 KB. The low 16 address bits go through untouched. The upper 16 bits are the virtual page number, and they are replaced by a 12-bit physical page number held in the matching entry.

Each entry is tagged with both the virtual page number and an 8-bit process identifier. Translations that belong to different processes can therefore sit in the cache together, and a context switch does not require a flush. When no entry matches, the block reports a miss. An external handler then walks the page tables and installs the translation through the fill port. When the fill tag is already present, the existing entry is updated in place. Otherwise the fill goes to a slot chosen round-robin, with empty slots taken before occupied ones. A single flush input empties the whole cache.

The lookup outcome is one of four named result states, chosen each cycle:
- IDLE: no request is presented.
- MISS: a request matches no entry.
- GRANT: a request hits and the permissions allow it.
- TRAP: a request hits but the permissions forbid it.

Movement between these result states is purely combinational from the request and the stored entries. The only sequential state is:
- the entry store: valid bit, tag, page number and permissions;
- the replacement pointer. It moves from its current slot to the slot after the victim on every allocating fill, and it stays where it is on an in-place update, on a flush and on an idle cycle.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `pa_out` equals the 12-bit physical page number of the matching entry followed by `lk_vaddr[15:0]` unchanged. On no hit, `pa_out` is zero.
- R2: A lookup hits only when a valid entry holds both `lk_vaddr[31:16]` and `lk_asid`. The same page number under two different process identifiers occupies two independent entries.
- R3: When `lk_valid` is high, exactly one of `hit` and `miss` is high. When no entry matches, `miss` is high and both `hit` and `trap` are low. When `lk_valid` is low, `hit`, `miss` and `trap` are all low.
- R4: The access kind is encoded on `lk_kind` as follows, using permission bits bit0 = read, bit1 = write and bit2 = execute of `fill_perm`:
  - 2'b00 is a load and needs read.
  - 2'b01 is a store and needs write.
  - 2'b10 is a fetch and needs execute.
  - 2'b11 is handled like a load.
  A hit whose needed bit is clear raises `trap`.
- R5: `trap` is only ever high together with `hit`. A miss never raises `trap`.
- R6: A fill becomes visible to lookups from the cycle after the rising edge that captures it. A lookup in the same cycle as the fill sees the contents from before the fill.
- R7: A fill whose page number and process identifier match a valid entry rewrites that entry's page number and permissions. It creates no second entry and does not move the replacement pointer.
- R8: The cache holds 16 entries. An allocating fill goes to the first empty slot found by scanning upward from the replacement pointer, with wraparound. If every slot is full, it goes to the slot the pointer names. Afterwards the pointer moves to the slot after the one written.
- R9: `flush_all` empties every entry at one rising edge. When a fill arrives in the same cycle as `flush_all`, the fill is dropped. A flush does not move the replacement pointer.
- R10: After reset, all entries are empty and the replacement pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup request is present this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 as load |
| lk_asid | input | 8 | Identifier of the process making the access |
| pa_out | output | 28 | Translated physical address, zero without a hit |
| hit | output | 1 | Translation found |
| miss | output | 1 | Translation not found |
| trap | output | 1 | Found, but the access kind is not permitted |
| fill_en | input | 1 | Install or update one entry at the next rising edge |
| fill_vpn | input | 16 | Virtual page number of the entry being filled |
| fill_asid | input | 8 | Process identifier of the entry being filled |
| fill_ppn | input | 12 | Physical page number of the entry being filled |
| fill_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush_all | input | 1 | Empty the whole cache at the next rising edge |

## Verification
The outputs `hit`, `miss`, `trap` and `pa_out` for a lookup are due in the same cycle as the request, because no register sits between the request and those outputs. The bench drives each request just after a falling edge and compares it 2 ns later, well before the next rising edge. A fill or flush only takes effect at the rising edge that follows it, so its result is checked by a lookup issued in a later cycle. One deliberate lookup issued alongside a fill must still see the old contents. The driver computes each expected result from its own model of the entries and the replacement pointer at the moment it issues the request, and a monitor pops and compares that result in the cycle it is due.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    parameter int VA_W   = 32;
    parameter int PA_W   = 28;
    parameter int OFS_W  = 16;
    parameter int ASID_W = 8;
    parameter int NENT   = 16;

    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int IDX_W = $clog2(NENT);

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RES_IDLE,
        RES_MISS,
        RES_GRANT,
        RES_TRAP
    } res_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
    } tag_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } data_t;

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = NENT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tag_t         look_tag,
    input  tag_t         fill_tag,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  data_t        wr_data,
    output logic [N-1:0] look_hit_vec,
    output logic [N-1:0] fill_hit_vec,
    output logic [N-1:0] valid_vec,
    output data_t        look_data
);

    logic  [N-1:0] valid_q;
    tag_t          tag_q  [N];
    data_t         data_q [N];

    // entry store: flush has priority over a write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= fill_tag;
            data_q[wr_idx]  <= wr_data;
        end
    end

    // one comparator pair per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign look_hit_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
        assign fill_hit_vec[g] = valid_q[g] && (tag_q[g] == fill_tag);
    end

    assign valid_vec = valid_q;

    // one-hot read mux
    always_comb begin
        look_data = '0;
        for (int i = 0; i < N; i++) begin
            if (look_hit_vec[i]) look_data = look_data | data_q[i];
        end
    end

    // R7: in-place update keeps every tag unique
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(look_hit_vec) <= 1);

    // R9: a flush leaves no entry valid
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int N = NENT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid_vec,
    input  logic                 alloc,
    output logic [$clog2(N)-1:0] victim_idx
);

    localparam int IW = $clog2(N);

    logic [IW-1:0] rr_q;
    logic          found;

    // first empty slot scanning upward from the pointer, else the pointer
    always_comb begin
        found      = 1'b0;
        victim_idx = rr_q;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(rr_q) + k) % N;
            if (!found && !valid_vec[idx]) begin
                found      = 1'b1;
                victim_idx = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (alloc) begin
            rr_q <= IW'((int'(victim_idx) + 1) % N);
        end
    end

    // R8: while any slot is empty, the chosen slot is empty
    p_victim_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != '1) |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  logic  req,
    input  logic  found,
    input  acc_e  kind,
    input  perm_t perm,
    output res_e  res
);

    logic allowed;

    always_comb begin
        unique case (kind)
            ACC_LOAD:  allowed = perm.r;
            ACC_STORE: allowed = perm.w;
            ACC_FETCH: allowed = perm.x;
            ACC_RSVD:  allowed = perm.r;
            default:   allowed = 1'b0;
        endcase
    end

    // result-state selection
    always_comb begin
        if (!req)          res = RES_IDLE;
        else if (!found)   res = RES_MISS;
        else if (allowed)  res = RES_GRANT;
        else               res = RES_TRAP;
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [PA_W-1:0]   pa_out,
    output logic              hit,
    output logic              miss,
    output logic              trap,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [2:0]        fill_perm,
    input  logic              flush_all
);

    tag_t             look_tag, fill_tag;
    data_t            look_data, wr_data;
    logic [NENT-1:0]  look_hit_vec, fill_hit_vec, valid_vec;
    logic [IDX_W-1:0] victim_idx, fill_idx, wr_idx;
    logic             any_look, fill_match, wr_en, alloc;
    res_e             res;

    assign look_tag = '{vpn: lk_vaddr[VA_W-1:OFS_W], asid: lk_asid};
    assign fill_tag = '{vpn: fill_vpn, asid: fill_asid};
    assign wr_data  = '{ppn: fill_ppn, perm: perm_t'(fill_perm)};

    xlat_match #(.N(NENT)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_tag     (look_tag),
        .fill_tag     (fill_tag),
        .flush        (flush_all),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .look_hit_vec (look_hit_vec),
        .fill_hit_vec (fill_hit_vec),
        .valid_vec    (valid_vec),
        .look_data    (look_data)
    );

    xlat_victim #(.N(NENT)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .alloc      (alloc),
        .victim_idx (victim_idx)
    );

    // slot of an entry that already carries the fill tag
    always_comb begin
        fill_idx = '0;
        for (int i = 0; i < NENT; i++) begin
            if (fill_hit_vec[i]) fill_idx = IDX_W'(i);
        end
    end

    assign any_look   = |look_hit_vec;
    assign fill_match = |fill_hit_vec;
    assign wr_en      = fill_en && !flush_all;
    assign alloc      = wr_en && !fill_match;
    assign wr_idx     = fill_match ? fill_idx : victim_idx;

    xlat_perm u_perm (
        .req   (lk_valid),
        .found (any_look),
        .kind  (acc_e'(lk_kind)),
        .perm  (look_data.perm),
        .res   (res)
    );

    // outputs per result state
    always_comb begin
        hit  = 1'b0;
        miss = 1'b0;
        trap = 1'b0;
        unique case (res)
            RES_IDLE:  ;
            RES_MISS:  miss = 1'b1;
            RES_GRANT: hit  = 1'b1;
            RES_TRAP: begin
                hit  = 1'b1;
                trap = 1'b1;
            end
            default:   ;
        endcase
    end

    assign pa_out = hit ? {look_data.ppn, lk_vaddr[OFS_W-1:0]} : '0;

    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (hit ^ miss));

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(hit || miss || trap));

    p_trap_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> hit);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa_out[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

    p_no_hit_after_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !hit);

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic [7:0]  lk_asid = '0;
    logic [27:0] pa_out;
    logic        hit, miss, trap;
    logic        fill_en = 1'b0;
    logic [15:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [11:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_all = 1'b0;

    always #4 clk = ~clk;

    xlat_cache u_dut (.*);

    typedef struct {
        logic        e_hit;
        logic        e_miss;
        logic        e_trap;
        logic [27:0] e_pa;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    // bench model of the cache
    logic        m_val  [16];
    logic [15:0] m_vpn  [16];
    logic [7:0]  m_asid [16];
    logic [11:0] m_ppn  [16];
    logic [2:0]  m_perm [16];
    int          m_rr;

    function automatic exp_t predict(logic [31:0] va, logic [1:0] kind,
                                     logic [7:0] asid, string req);
        exp_t e;
        e = '{1'b0, 1'b1, 1'b0, 28'd0, req};
        for (int i = 0; i < 16; i++) begin
            if (m_val[i] && m_vpn[i] == va[31:16] && m_asid[i] == asid) begin
                logic need;
                case (kind)
                    2'b01:   need = m_perm[i][1];
                    2'b10:   need = m_perm[i][2];
                    default: need = m_perm[i][0];
                endcase
                e.e_hit  = 1'b1;
                e.e_miss = 1'b0;
                e.e_trap = !need;
                e.e_pa   = {m_ppn[i], va[15:0]};
            end
        end
        return e;
    endfunction

    function automatic void model_fill(logic [15:0] vpn, logic [7:0] asid,
                                       logic [11:0] ppn, logic [2:0] perm);
        int slot;
        bit same;
        slot = -1;
        same = 0;
        for (int i = 0; i < 16; i++)
            if (m_val[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
                slot = i;
                same = 1;
            end
        if (!same) begin
            for (int k = 0; k < 16; k++)
                if (slot < 0 && !m_val[(m_rr + k) % 16]) slot = (m_rr + k) % 16;
            if (slot < 0) slot = m_rr;
            m_rr = (slot + 1) % 16;
        end
        m_val[slot]  = 1'b1;
        m_vpn[slot]  = vpn;
        m_asid[slot] = asid;
        m_ppn[slot]  = ppn;
        m_perm[slot] = perm;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: results are due 2 ns after the falling edge that drove them
    always begin
        @(negedge clk);
        #2;
        if (lk_valid) begin
            if (q.size() == 0) begin
                check("R3 unexpected request", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " hit"},  {31'd0, hit},  {31'd0, e.e_hit});
                check({e.req, " miss"}, {31'd0, miss}, {31'd0, e.e_miss});
                check({e.req, " trap"}, {31'd0, trap}, {31'd0, e.e_trap});
                check({e.req, " pa"},   {4'd0, pa_out}, {4'd0, e.e_pa});
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        lk_valid  = 1'b0;
        fill_en   = 1'b0;
        flush_all = 1'b0;
    endtask

    task automatic look(logic [31:0] va, logic [1:0] kind, logic [7:0] asid, string req);
        @(negedge clk);
        fill_en   = 1'b0;
        flush_all = 1'b0;
        lk_valid  = 1'b1;
        lk_vaddr  = va;
        lk_kind   = kind;
        lk_asid   = asid;
        q.push_back(predict(va, kind, asid, req));
    endtask

    task automatic fill(logic [15:0] vpn, logic [7:0] asid, logic [11:0] ppn,
                        logic [2:0] perm, bit with_flush);
        @(negedge clk);
        lk_valid  = 1'b0;
        fill_en   = 1'b1;
        fill_vpn  = vpn;
        fill_asid = asid;
        fill_ppn  = ppn;
        fill_perm = perm;
        flush_all = with_flush;
        if (with_flush) begin
            for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
        end else begin
            model_fill(vpn, asid, ppn, perm);
        end
    endtask

    task automatic flush();
        @(negedge clk);
        lk_valid  = 1'b0;
        fill_en   = 1'b0;
        flush_all = 1'b1;
        for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        check("watchdog expired", 32'd1, 32'd0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        end
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_val[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0;
            m_ppn[i] = '0;   m_perm[i] = '0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: empty after reset
        look(32'h1234_5678, 2'b00, 8'd5, "R10 reset miss");
        look(32'h0000_0000, 2'b10, 8'd0, "R10 reset miss zero");
        idle();
        #2;
        // R3: no request, all outputs low
        check("R3 idle hit",  {31'd0, hit},  32'd0);
        check("R3 idle miss", {31'd0, miss}, 32'd0);
        check("R3 idle trap", {31'd0, trap}, 32'd0);

        // R1, R4: read-write page
        fill(16'h1234, 8'd5, 12'hABC, 3'b011, 0);
        look(32'h1234_5678, 2'b00, 8'd5, "R1 load hit pa");
        look(32'h1234_FFFF, 2'b01, 8'd5, "R4 store allowed");
        look(32'h1234_0001, 2'b10, 8'd5, "R4 R5 fetch trap");
        // R2: other process misses, then coexists
        look(32'h1234_5678, 2'b00, 8'd6, "R2 other asid miss");
        fill(16'h1234, 8'd6, 12'h111, 3'b100, 0);
        look(32'h1234_0042, 2'b10, 8'd6, "R2 fetch hit asid6");
        look(32'h1234_0042, 2'b00, 8'd6, "R4 load trap no read");
        look(32'h1234_0042, 2'b00, 8'd5, "R2 asid5 kept");
        look(32'h1235_0042, 2'b00, 8'd5, "R3 neighbour page miss");

        // R6: lookup in the fill cycle sees old contents
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = 32'h2000_0010; lk_kind = 2'b00; lk_asid = 8'd1;
        fill_en = 1'b1; fill_vpn = 16'h2000; fill_asid = 8'd1;
        fill_ppn = 12'h222; fill_perm = 3'b001; flush_all = 1'b0;
        q.push_back(predict(32'h2000_0010, 2'b00, 8'd1, "R6 same cycle miss"));
        model_fill(16'h2000, 8'd1, 12'h222, 3'b001);
        look(32'h2000_0010, 2'b00, 8'd1, "R6 next cycle hit");

        // R7: in-place update
        fill(16'h1234, 8'd5, 12'h0F0, 3'b001, 0);
        look(32'h1234_00AA, 2'b00, 8'd5, "R7 updated ppn");
        look(32'h1234_00AA, 2'b01, 8'd5, "R7 updated perm store trap");

        // R4: reserved kind behaves as load
        look(32'h1234_00AA, 2'b11, 8'd5, "R4 kind3 read ok");
        look(32'h1234_00AA, 2'b11, 8'd6, "R4 kind3 trap on exec-only");

        // R9: flush, and flush beats fill
        flush();
        look(32'h1234_00AA, 2'b00, 8'd5, "R9 flushed asid5");
        look(32'h2000_0010, 2'b00, 8'd1, "R9 flushed asid1");
        fill(16'h3000, 8'd3, 12'h333, 3'b111, 1);
        look(32'h3000_0000, 2'b00, 8'd3, "R9 fill dropped");

        // R8: fill all 16 slots, then one more evicts the pointer slot
        for (int i = 0; i < 16; i++)
            fill(16'h4000 + 16'(i), 8'd2, 12'h400 + 12'(i), 3'b111, 0);
        for (int i = 0; i < 16; i++)
            look({16'h4000 + 16'(i), 16'h0100}, 2'b01, 8'd2, "R8 full set hit");
        fill(16'h5000, 8'd2, 12'h500, 3'b001, 0);
        fill(16'h5001, 8'd2, 12'h501, 3'b001, 0);
        for (int i = 0; i < 16; i++)
            look({16'h4000 + 16'(i), 16'h0200}, 2'b00, 8'd2, "R8 after eviction");
        look(32'h5000_0003, 2'b00, 8'd2, "R8 new entry hit");
        look(32'h5001_0004, 2'b01, 8'd2, "R8 new entry store trap");
        idle();
        idle();

        if (q.size() != 0) check("R3 results outstanding", 32'(q.size()), 32'd0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        end
        $finish;
    end

endmodule